// File: doc/BRIEF.md
# Wrapping Byte-Window Pointer Unit

This block gives a host byte-serial access to a 24 KB packet memory, with addresses from 0000h to 5FFFh, through two data windows. One window serves the receive area and the other serves a region that the host defines. Each window keeps its own read pointer and its own write pointer. Every byte that moves through a window advances the matching pointer by one, so the host can stream a packet without reloading any address. Wrapping is not a plain modulo step. The receive pointers fall back from the top of memory to a programmable receive start address. This is the same rule the receive hardware follows, so a packet can be read out straight across the wrap point. The user-window pointers first test a host-set end address, which wins over every other rule, and only then test the top of memory.

The unit drives a single-port synchronous memory. One access is made per cycle, and a write takes precedence over a read. A small controller tracks the previous cycle's access with four states. IDLE means nothing was issued. WRITE means a write was issued. READ means a read was issued, so the data is valid now. HOLD means a write was issued while a read waited. From any state, the next state is chosen only by this cycle's requests: write and read together go to HOLD, write alone goes to WRITE, read alone goes to READ, and no request goes to IDLE.

The host loads pointers and bounds through a configuration port. The receive start address is locked while reception is enabled.

Top module: `bufwin_ptr_unit`

## Requirements
- R1: After reset all four pointers, the receive start address and the user start address are 0000h, the user end address is 5FFFh, and the error flag is low.
- R2: An accepted window access drives `mem_addr` with the current pointer of that window (read pointer for reads, write pointer for writes), and that pointer then steps by +1 when no wrap rule applies.
- R3: A receive pointer at 5FFFh steps to the receive start address.
- R4: A user pointer equal to the user end address steps to the user start address, whatever the other rules say.
- R5: A user pointer at 5FFFh steps to 0000h when the user end address is not 5FFFh.
- R6: A user pointer at 5FFFh steps to the user start address when the user end address is 5FFFh.
- R7: A `cfg_sel`=4 write while `rx_en` is high leaves the receive start address unchanged and sets `rx_start_err`. The flag stays set until reset.
- R8: When `cfg_we` is high, `cfg_wdata` loads the register chosen by `cfg_sel` (0 receive read pointer, 1 receive write pointer, 2 user read pointer, 3 user write pointer, 4 receive start, 5 user start, 6 user end). A pointer load wins over an increment in the same cycle.
- R9: `rd_valid` is high, and `rd_data` holds the byte at the accessed address, in the cycle after a read is accepted.
- R10: When a read and a write are requested together, the write is issued, `rd_ready` is low, and the held read is accepted on the next cycle that has no write request.
- R11: The user start and end addresses load and take effect even while `rx_en` is high.
- R12: `mem_we` and `mem_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Reception enabled; locks the receive start address |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_sel | input | 3 | Register selector for loads (codes in R8) |
| cfg_wdata | input | 15 | Load value |
| rd_req | input | 1 | Window read request, held until `rd_ready` |
| rd_sel | input | 1 | Read window: 0 receive, 1 user |
| rd_ready | output | 1 | Read accepted this cycle |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read byte |
| wr_req | input | 1 | Window write request |
| wr_sel | input | 1 | Write window: 0 receive, 1 user |
| wr_data | input | 8 | Byte to write |
| mem_addr | output | 15 | Memory byte address |
| mem_re | output | 1 | Memory read enable |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_re` |
| rx_start_err | output | 1 | Sticky flag for a blocked receive-start load |

## Verification
The bench targets the wrap points. A receive read crosses 5FFFh, and a design that wraps to zero would expose it by issuing 0000h in place of the start address. A user pointer meets its end address below the top of memory, where a design with the priority reversed would run on past the bound. A user pointer reaches 5FFFh with the end address placed elsewhere and again with the end address set to 5FFFh, which separates a return to zero from a return to the start address. Further cases collide a load with an increment, collide a read with a write, and try a receive-start load while reception is on. A design that let the increment win, served the read first, or accepted the locked load would show a wrong next address or a wrong read byte.

// File: rtl/bufwin_pkg.sv
package bufwin_pkg;

    localparam int NUM_PTR = 4;

    // Configuration register selector codes
    typedef enum logic [2:0] {
        SEL_RX_RD    = 3'd0,
        SEL_RX_WR    = 3'd1,
        SEL_UD_RD    = 3'd2,
        SEL_UD_WR    = 3'd3,
        SEL_RX_START = 3'd4,
        SEL_UD_START = 3'd5,
        SEL_UD_END   = 3'd6,
        SEL_NONE     = 3'd7
    } cfg_sel_e;

    // Access controller: what was issued in the previous cycle
    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_WRITE = 2'd1,
        ARB_READ  = 2'd2,
        ARB_HOLD  = 2'd3
    } arb_state_e;

endpackage

// File: rtl/bufwin_step.sv
// Next-address rule: the end bound wins, then the top of memory, then +1.
module bufwin_step #(
    parameter int                ADDR_W   = 15,
    parameter logic [ADDR_W-1:0] MEM_LAST = 15'h5FFF
) (
    input  logic [ADDR_W-1:0] cur,
    input  logic [ADDR_W-1:0] wrap_start,
    input  logic [ADDR_W-1:0] wrap_end,
    output logic [ADDR_W-1:0] nxt
);

    always_comb begin
        if (cur == wrap_end) begin
            nxt = wrap_start;
        end else if (cur == MEM_LAST) begin
            nxt = '0;
        end else begin
            nxt = cur + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/bufwin_arb.sv
module bufwin_arb
    import bufwin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    output logic rd_accept,
    output logic wr_accept,
    output logic rd_valid
);

    arb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case ({wr_req, rd_req})
            2'b11:   state_d = ARB_HOLD;
            2'b10:   state_d = ARB_WRITE;
            2'b01:   state_d = ARB_READ;
            default: state_d = ARB_IDLE;
        endcase
    end

    always_comb begin
        wr_accept = wr_req;
        rd_accept = rd_req && !wr_req;
        rd_valid  = (state_q == ARB_READ);
    end

endmodule

// File: rtl/bufwin_ptr_unit.sv
module bufwin_ptr_unit
    import bufwin_pkg::*;
#(
    parameter int                ADDR_W   = 15,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] MEM_LAST = 15'h5FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              rd_req,
    input  logic              rd_sel,
    output logic              rd_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_req,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rx_start_err
);

    localparam int PTR_IDX_W = $clog2(NUM_PTR);

    logic [ADDR_W-1:0] rx_start_q, ud_start_q, ud_end_q;
    logic [ADDR_W-1:0] ptr_q   [NUM_PTR];
    logic [ADDR_W-1:0] ptr_nxt [NUM_PTR];
    logic              rd_accept, wr_accept;
    logic [PTR_IDX_W-1:0] rd_idx, wr_idx;
    logic              err_q;

    bufwin_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .rd_accept (rd_accept),
        .wr_accept (wr_accept),
        .rd_valid  (rd_valid)
    );

    assign rd_idx = {rd_sel, 1'b0};
    assign wr_idx = {wr_sel, 1'b1};

    // Index 0/1: receive read/write, 2/3: user read/write
    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        localparam bit IS_RX = (i < 2);
        logic step_en;

        bufwin_step #(.ADDR_W(ADDR_W), .MEM_LAST(MEM_LAST)) u_step (
            .cur        (ptr_q[i]),
            .wrap_start (IS_RX ? rx_start_q : ud_start_q),
            .wrap_end   (IS_RX ? MEM_LAST   : ud_end_q),
            .nxt        (ptr_nxt[i])
        );

        assign step_en = (rd_accept && (rd_idx == PTR_IDX_W'(i))) ||
                         (wr_accept && (wr_idx == PTR_IDX_W'(i)));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[i] <= '0;
            end else if (cfg_we && (cfg_sel == 3'(i))) begin
                ptr_q[i] <= cfg_wdata;
            end else if (step_en) begin
                ptr_q[i] <= ptr_nxt[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_start_q <= '0;
            ud_start_q <= '0;
            ud_end_q   <= MEM_LAST;
            err_q      <= 1'b0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_RX_START) begin
                if (rx_en) begin
                    err_q <= 1'b1;
                end else begin
                    rx_start_q <= cfg_wdata;
                end
            end
            if (cfg_sel == SEL_UD_START) begin
                ud_start_q <= cfg_wdata;
            end
            if (cfg_sel == SEL_UD_END) begin
                ud_end_q <= cfg_wdata;
            end
        end
    end

    always_comb begin
        mem_we    = wr_accept;
        mem_re    = rd_accept;
        mem_addr  = wr_accept ? ptr_q[wr_idx] : ptr_q[rd_idx];
        mem_wdata = wr_data;
        rd_ready  = rd_accept;
        rd_data   = rd_valid ? mem_rdata : '0;
        rx_start_err = err_q;
    end

endmodule

// File: rtl/bufwin_ptr_unit_chk.sv
module bufwin_ptr_unit_chk #(
    parameter int                ADDR_W   = 15,
    parameter logic [ADDR_W-1:0] MEM_LAST = 15'h5FFF
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_en,
    input logic              cfg_we,
    input logic [2:0]        cfg_sel,
    input logic              rd_req,
    input logic              rd_sel,
    input logic              rd_ready,
    input logic              rd_valid,
    input logic              wr_req,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              rx_start_err,
    input logic [ADDR_W-1:0] rx_start_q,
    input logic [ADDR_W-1:0] rx_rd_ptr
);

    logic rx_rd_go;
    assign rx_rd_go = rd_req && rd_ready && !rd_sel && !(cfg_we && cfg_sel == 3'd0);

    assert_single_port_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_write_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_req) |-> (!rd_ready && mem_we));

    assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ready) |=> rd_valid);

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start_err |=> rx_start_err);

    assert_start_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 3'd4 && rx_en) |=> ($stable(rx_start_q) && rx_start_err));

    assert_rx_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_go && mem_addr == MEM_LAST) |=> (rx_rd_ptr == $past(rx_start_q)));

    assert_rx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd_go && mem_addr != MEM_LAST) |=> (rx_rd_ptr == $past(mem_addr) + ADDR_W'(1)));

endmodule

bind bufwin_ptr_unit bufwin_ptr_unit_chk #(.ADDR_W(ADDR_W), .MEM_LAST(MEM_LAST)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_en        (rx_en),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .rd_req       (rd_req),
    .rd_sel       (rd_sel),
    .rd_ready     (rd_ready),
    .rd_valid     (rd_valid),
    .wr_req       (wr_req),
    .mem_we       (mem_we),
    .mem_re       (mem_re),
    .mem_addr     (mem_addr),
    .rx_start_err (rx_start_err),
    .rx_start_q   (rx_start_q),
    .rx_rd_ptr    (ptr_q[0])
);

// File: tb/bufwin_ptr_unit_bench.sv
module bufwin_ptr_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [14:0] cfg_wdata = '0;
    logic        rd_req = 1'b0, rd_sel = 1'b0;
    logic        rd_ready, rd_valid;
    logic [7:0]  rd_data;
    logic        wr_req = 1'b0, wr_sel = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [14:0] mem_addr;
    logic        mem_re, mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        rx_start_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] wmem [int];

    always #2 clk = ~clk;

    bufwin_ptr_unit u_bufwin_ptr_unit (.*);

    function automatic logic [7:0] model_rd(logic [14:0] a);
        if (wmem.exists(int'(a))) return wmem[int'(a)];
        return a[7:0] ^ {1'b0, a[14:8]};
    endfunction

    always @(posedge clk) begin
        if (mem_we) wmem[int'(mem_addr)] = mem_wdata;
        if (mem_re) mem_rdata <= model_rd(mem_addr);
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(logic [2:0] s, logic [14:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(logic w, logic [14:0] exp, string tag);
        @(negedge clk);
        rd_req = 1'b1; rd_sel = w;
        #1;
        chk(rd_ready && mem_re && mem_addr == exp, {tag, " read address"}, int'(mem_addr), int'(exp));
        @(negedge clk);
        rd_req = 1'b0;
        chk(rd_valid && rd_data == model_rd(exp), {tag, " read data"}, int'(rd_data), int'(model_rd(exp)));
    endtask

    task automatic wr(logic w, logic [7:0] d, logic [14:0] exp, string tag);
        @(negedge clk);
        wr_req = 1'b1; wr_sel = w; wr_data = d;
        #1;
        chk(mem_we && !mem_re && mem_addr == exp && mem_wdata == d, {tag, " write address"},
            int'(mem_addr), int'(exp));
        @(negedge clk);
        wr_req = 1'b0;
    endtask

    // {op[1:0], sel[2:0], req[3:0], val[14:0], exp[14:0]}; op 0 load, 1 read, 2 write
    localparam int NV = 30;
    localparam logic [38:0] VEC [0:NV-1] = '{
        {2'd0, 3'd4, 4'd8, 15'h5000, 15'h0000},  // R8 receive start
        {2'd0, 3'd0, 4'd8, 15'h5FFE, 15'h0000},  // R8
        {2'd1, 3'd0, 4'd2, 15'h0000, 15'h5FFE},  // R2
        {2'd1, 3'd0, 4'd2, 15'h0000, 15'h5FFF},  // R2
        {2'd1, 3'd0, 4'd3, 15'h0000, 15'h5000},  // R3 wrap to start
        {2'd1, 3'd0, 4'd2, 15'h0000, 15'h5001},  // R2
        {2'd0, 3'd1, 4'd8, 15'h5FFF, 15'h0000},  // R8
        {2'd2, 3'd0, 4'd2, 15'h00A5, 15'h5FFF},  // R2
        {2'd2, 3'd0, 4'd3, 15'h003C, 15'h5000},  // R3 write wrap
        {2'd1, 3'd0, 4'd2, 15'h0000, 15'h5002},  // R2 pointers independent
        {2'd0, 3'd5, 4'd8, 15'h0100, 15'h0000},  // R8
        {2'd0, 3'd6, 4'd8, 15'h0102, 15'h0000},  // R8
        {2'd0, 3'd2, 4'd8, 15'h0101, 15'h0000},  // R8
        {2'd1, 3'd1, 4'd2, 15'h0000, 15'h0101},  // R2
        {2'd1, 3'd1, 4'd2, 15'h0000, 15'h0102},  // R2
        {2'd1, 3'd1, 4'd4, 15'h0000, 15'h0100},  // R4 end -> start
        {2'd0, 3'd2, 4'd8, 15'h5FFF, 15'h0000},  // R8
        {2'd1, 3'd1, 4'd5, 15'h0000, 15'h5FFF},  // R5
        {2'd1, 3'd1, 4'd5, 15'h0000, 15'h0000},  // R5 top -> zero
        {2'd0, 3'd6, 4'd8, 15'h5FFF, 15'h0000},  // R8
        {2'd0, 3'd3, 4'd8, 15'h5FFF, 15'h0000},  // R8
        {2'd2, 3'd1, 4'd6, 15'h0077, 15'h5FFF},  // R6
        {2'd2, 3'd1, 4'd6, 15'h0088, 15'h0100},  // R6 top is end -> start
        {2'd0, 3'd6, 4'd8, 15'h0040, 15'h0000},  // R8 end below start
        {2'd0, 3'd2, 4'd8, 15'h0040, 15'h0000},  // R8
        {2'd1, 3'd1, 4'd4, 15'h0000, 15'h0040},  // R4
        {2'd1, 3'd1, 4'd4, 15'h0000, 15'h0100},  // R4
        {2'd0, 3'd0, 4'd8, 15'h5FFF, 15'h0000},  // R8
        {2'd1, 3'd0, 4'd9, 15'h0000, 15'h5FFF},  // R9 byte written earlier
        {2'd1, 3'd0, 4'd9, 15'h0000, 15'h5000}   // R9
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        chk(!rx_start_err && !mem_we && !mem_re && !rd_valid, "R1 idle outputs",
            int'(rx_start_err), 0);
        rd(1'b0, 15'h0000, "R1 receive pointer");
        rd(1'b1, 15'h0000, "R1 user pointer");

        for (int k = 0; k < NV; k++) begin
            logic [38:0] v;
            string tag;
            v = VEC[k];
            tag = $sformatf("R%0d row %0d", v[33:30], k);
            unique case (v[38:37])
                2'd0:    cfg(v[36:34], v[29:15]);
                2'd1:    rd(v[34], v[14:0], tag);
                default: wr(v[34], v[22:15], v[14:0], tag);
            endcase
        end

        // R7 locked receive start
        rx_en = 1'b1;
        cfg(3'd4, 15'h4000);
        chk(rx_start_err, "R7 error flag set", int'(rx_start_err), 1);
        rx_en = 1'b0;
        cfg(3'd0, 15'h5FFF);
        rd(1'b0, 15'h5FFF, "R7");
        rd(1'b0, 15'h5000, "R7 start unchanged");
        chk(rx_start_err, "R7 flag sticky", int'(rx_start_err), 1);

        // R8 load beats increment
        @(negedge clk);
        rd_req = 1'b1; rd_sel = 1'b0;
        cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 15'h1234;
        #1;
        chk(mem_re && mem_addr == 15'h5001, "R8 collide address", int'(mem_addr), 'h5001);
        @(negedge clk);
        rd_req = 1'b0; cfg_we = 1'b0;
        rd(1'b0, 15'h1234, "R8 load wins");

        // R10 write before read
        @(negedge clk);
        rd_req = 1'b1; rd_sel = 1'b0;
        wr_req = 1'b1; wr_sel = 1'b0; wr_data = 8'h5A;
        #1;
        chk(!rd_ready && mem_we && !mem_re && mem_addr == 15'h5001, "R10 write served",
            int'(mem_addr), 'h5001);
        @(negedge clk);
        wr_req = 1'b0;
        chk(!rd_valid, "R10 no data for held read", int'(rd_valid), 0);
        #1;
        chk(rd_ready && mem_re && mem_addr == 15'h1235, "R10 held read issued",
            int'(mem_addr), 'h1235);
        @(negedge clk);
        rd_req = 1'b0;
        chk(rd_valid && rd_data == model_rd(15'h1235), "R10 held read data",
            int'(rd_data), int'(model_rd(15'h1235)));
        cfg(3'd0, 15'h5001);
        rd(1'b0, 15'h5001, "R10 written byte");
        chk(model_rd(15'h5001) == 8'h5A, "R10 stored byte", int'(model_rd(15'h5001)), 'h5A);

        // R11 user bounds while receiving
        rx_en = 1'b1;
        cfg(3'd5, 15'h0200);
        cfg(3'd6, 15'h0300);
        cfg(3'd2, 15'h0300);
        rd(1'b1, 15'h0300, "R11");
        rd(1'b1, 15'h0200, "R11 new bounds used");
        rx_en = 1'b0;

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule